// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block manages the free space of a shared packet buffer built from 256-byte pages. A host drives an 8-bit command word. The top three bits select an operation. The low five bits give a page count when the operation is an allocation. The block searches its free-page bitmap for the lowest run of contiguous free pages that is long enough. It marks those pages as used and reports the first page index as the packet number. When no run is long enough, it reports a failure code instead.

The block also holds three packet-number queues. The receive queue is filled by the MAC and drained by host commands. The transmit queue is filled by host commands and drained by the MAC. The transmit-done queue collects packets that the MAC has finished sending, and the host pops it. Returning a packet's pages to the pool (a release) is a multi-cycle operation, and a busy flag is high while one is running. With auto-release enabled, a successfully sent packet gives back its pages without any host command. Simple valid strobes stand in for the MAC side.

Top module: `pgalloc_top`

## Requirements
- R1: `cmdWord[7:5]` selects the operation when `cmdValid` is high: 0 no-op, 1 allocate, 2 reset allocator, 3 drop receive head, 4 drop receive head and release its pages, 5 release packet `pktNumIn`, 6 enqueue `pktNumIn` for transmit, 7 reset transmit queues. A no-op changes nothing.
- R2: An allocate requests `cmdWord[4:0]+1` pages. On the clock edge after the command, `allocResult` holds `{2'b00, start}`. Here `start` is the lowest page index that begins a run of that many free pages lying wholly inside the 32-page buffer. Those pages become used.
- R3: If no such run exists, `allocResult` becomes 8'h80 (bit 7 set, other bits zero), and no page changes state.
- R4: `allocDone` is high for exactly the one cycle after each allocate command, whether it succeeds or fails.
- R5: A release is started by command 5, by command 4 with a non-empty receive queue, or by auto-release. Once started, `busy` is high for exactly 4 cycles. The packet's pages become free in the same edge that `busy` falls. A release request that arrives while `busy` is high is ignored; for command 4 this includes the queue pop. Releasing a number that is not the start of an allocated packet frees nothing.
- R6: Command 3 pops the receive head and keeps its pages in use. Command 4 pops the head and releases that packet's pages. Both do nothing on an empty queue.
- R7: `rxFifoPort` has bit 15 set and all other bits zero when the receive queue is empty. Otherwise it reads `{10'b0, head}`. `rxPushValid` appends `rxPushPkt`.
- R8: Command 6 appends `pktNumIn` to the transmit queue. `txHeadValid` and `txHeadPkt` show its head, and `txHeadPkt` is 0 when the queue is empty.
- R9: `txPopValid` pops a non-empty transmit queue. If `txPopOk`, `autoRelease` and not busy all hold, and no host release starts in the same cycle, the popped packet is released. Otherwise it is appended to the done queue. `txFifoPort` reads 8'h80 when the done queue is empty, and `{2'b00, head}` otherwise. `doneRead` pops the done queue.
- R10: Command 2 frees every page, empties all three queues, cancels a running release and drops MAC strobes of that cycle. `allocResult` keeps its value.
- R11: Command 7 empties the transmit and done queues only. Pages, the receive queue and the allocation result are untouched.
- R12: Each queue holds 32 entries. A push into a full queue is dropped unless the same queue pops in the same cycle.
- R13: After reset, `allocResult` is 8'h80, `allocDone` and `busy` are 0, and all queues are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdWord | input | 8 | Operation in [7:5], page count minus one in [4:0] |
| pktNumIn | input | 6 | Packet number for release and enqueue |
| autoRelease | input | 1 | Free pages of successfully sent packets automatically |
| rxPushValid | input | 1 | MAC appends a received packet |
| rxPushPkt | input | 6 | Packet number of the received packet |
| txPopValid | input | 1 | MAC finished the transmit head |
| txPopOk | input | 1 | The finished transmission succeeded |
| doneRead | input | 1 | Host pops the done queue |
| allocResult | output | 8 | Failure flag in bit 7, packet number in [5:0] |
| allocDone | output | 1 | Allocation finished pulse |
| busy | output | 1 | Release in progress |
| rxFifoPort | output | 16 | Empty flag in bit 15, receive head in [5:0] |
| txFifoPort | output | 8 | Empty flag in bit 7, done head in [5:0] |
| txHeadValid | output | 1 | Transmit queue not empty |
| txHeadPkt | output | 6 | Transmit queue head |

## Verification
Some properties are checked on every cycle by the assertions:
- An allocate is always followed by a done pulse.
- A failed allocation leaves the page map untouched.
- A started release raises busy on the next cycle.
- Busy only falls after the page-freeing cycle or a full reset.
- A full queue never takes a push.

Other properties can only be shown by the bench's scenarios, because they depend on history:
- The lowest-fit placement.
- A drop keeping its pages while a release frees them.
- A release that was ignored while busy.
- Selective queue clearing.
- The choice between auto-release and the done queue.

These are judged against a reference model that is stepped with the same stimulus.

// File: rtl/pgalloc_pkg.sv
package pgalloc_pkg;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_ALLOC    = 3'd1,
    OP_RESET    = 3'd2,
    OP_RX_DROP  = 3'd3,
    OP_RX_FREE  = 3'd4,
    OP_FREE     = 3'd5,
    OP_TX_PUSH  = 3'd6,
    OP_TX_RESET = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    SRC_HOST = 2'd0,
    SRC_RX   = 2'd1,
    SRC_TX   = 2'd2
  } relSrc_e;

  typedef struct packed {
    logic    allocGo;
    logic    relGo;
    relSrc_e relSrc;
    logic    freeNow;
    logic    rxPush;
    logic    rxPop;
    logic    txPush;
    logic    txPop;
    logic    donePush;
    logic    donePop;
    logic    clrAll;
    logic    clrTx;
  } strobes_t;

endpackage

// File: rtl/pgalloc_fifo.sv
module pgalloc_fifo #(
  parameter int W     = 6,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] cnt;
  logic          full, doPop, doPush;

  assign empty  = (cnt == '0);
  assign full   = (cnt == CW'(DEPTH));
  assign doPop  = pop && !empty;
  assign doPush = push && (!full || doPop);
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= din;
        wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (doPop) rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      cnt <= cnt + CW'(doPush) - CW'(doPop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop && !clr) |=> (full && $stable(wrPtr)))
    else $error("queue accepted a push while full"); // R12

endmodule

// File: rtl/pgalloc_ctrl.sv
module pgalloc_ctrl
  import pgalloc_pkg::*;
#(
  parameter int REL_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       autoRelease,
  input  logic       rxPushValid,
  input  logic       txPopValid,
  input  logic       txPopOk,
  input  logic       doneRead,
  input  logic       rxEmpty,
  input  logic       txEmpty,
  output strobes_t   strb,
  output logic       busy
);
  localparam int CNT_W = $clog2(REL_CYC + 1);

  logic [CNT_W-1:0] relCnt;
  opcode_e          op;
  logic             busyNow, hostFree, rxRel, txPopAcc, autoRel;

  always_comb begin
    op       = cmdValid ? opcode_e'(cmdOp) : OP_NOP;
    busyNow  = (relCnt != '0);
    hostFree = (op == OP_FREE) && !busyNow;
    rxRel    = (op == OP_RX_FREE) && !busyNow && !rxEmpty;
    strb.clrAll = (op == OP_RESET);
    strb.clrTx  = (op == OP_TX_RESET);
    txPopAcc = txPopValid && !txEmpty && !strb.clrAll && !strb.clrTx;
    autoRel  = txPopAcc && txPopOk && autoRelease && !busyNow && !hostFree && !rxRel;

    strb.allocGo  = (op == OP_ALLOC);
    strb.relGo    = hostFree || rxRel || autoRel;
    strb.relSrc   = hostFree ? SRC_HOST : (rxRel ? SRC_RX : SRC_TX);
    strb.freeNow  = (relCnt == CNT_W'(1)) && !strb.clrAll;
    strb.rxPush   = rxPushValid && !strb.clrAll;
    strb.rxPop    = ((op == OP_RX_DROP) && !rxEmpty) || rxRel;
    strb.txPush   = (op == OP_TX_PUSH);
    strb.txPop    = txPopAcc;
    strb.donePush = txPopAcc && !autoRel;
    strb.donePop  = doneRead && !strb.clrAll && !strb.clrTx;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrAll) relCnt <= '0;
    else if (strb.relGo)      relCnt <= CNT_W'(REL_CYC);
    else if (busyNow)         relCnt <= relCnt - 1'b1;
  end

  assign busy = busyNow;

  AST_REL_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strb.relGo |=> busy)
    else $error("release started without busy"); // R5

  AST_BUSY_ENDS_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(strb.freeNow || strb.clrAll))
    else $error("busy fell without freeing"); // R5

endmodule

// File: rtl/pgalloc_dp.sv
module pgalloc_dp
  import pgalloc_pkg::*;
#(
  parameter int NP     = 32,
  parameter int PKT_W  = 6,
  parameter int REQ_W  = 5,
  parameter int QDEPTH = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strb,
  input  logic [REQ_W-1:0]   allocCode,
  input  logic [PKT_W-1:0]   hostPkt,
  input  logic [PKT_W-1:0]   rxPushPkt,
  output logic [PKT_W+1:0]   allocResult,
  output logic               allocDone,
  output logic               rxEmpty,
  output logic               txEmpty,
  output logic               doneEmpty,
  output logic [PKT_W-1:0]   rxHead,
  output logic [PKT_W-1:0]   txHead,
  output logic [PKT_W-1:0]   doneHead
);
  localparam int PG_W   = $clog2(NP);
  localparam int LEN_W  = REQ_W + 1;
  localparam int MAXREQ = 1 << REQ_W;

  logic [NP-1:0]    usedMap, freeMask, allocMask;
  logic [LEN_W-1:0] lens [NP];
  logic [PKT_W-1:0] relPkt, relSel;
  logic [PG_W-1:0]  relStart, fitStart;
  logic [LEN_W-1:0] relLen, needPages;
  logic             relValid, freeHit, fitFound, allocHit;

  // lowest-fit search over the free map
  assign needPages = LEN_W'(allocCode) + LEN_W'(1);
  always_comb begin
    logic ok;
    fitFound = 1'b0;
    fitStart = '0;
    for (int s = NP - 1; s >= 0; s--) begin
      ok = (s + int'(needPages) <= NP);
      for (int k = 0; k < MAXREQ; k++)
        if (k < int'(needPages) && s + k < NP && usedMap[PG_W'(s + k)]) ok = 1'b0;
      if (ok) begin
        fitFound = 1'b1;
        fitStart = PG_W'(s);
      end
    end
  end

  assign allocHit = strb.allocGo && fitFound;
  assign relValid = (relPkt < PKT_W'(NP));
  assign relStart = relPkt[PG_W-1:0];
  assign relLen   = lens[relStart];
  assign freeHit  = strb.freeNow && relValid;

  for (genvar i = 0; i < NP; i++) begin : g_mask
    assign freeMask[i]  = freeHit && (i >= int'(relStart)) &&
                          (i < int'(relStart) + int'(relLen));
    assign allocMask[i] = allocHit && (i >= int'(fitStart)) &&
                          (i < int'(fitStart) + int'(needPages));
  end

  always_comb begin
    case (strb.relSrc)
      SRC_HOST: relSel = hostPkt;
      SRC_RX:   relSel = rxHead;
      default:  relSel = txHead;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrAll) begin
      usedMap <= '0;
      for (int i = 0; i < NP; i++) lens[i] <= '0;
    end else begin
      usedMap <= (usedMap & ~freeMask) | allocMask;
      if (freeHit)  lens[relStart] <= '0;
      if (allocHit) lens[fitStart] <= needPages;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      relPkt      <= '0;
      allocResult <= {1'b1, {(PKT_W+1){1'b0}}};
      allocDone   <= 1'b0;
    end else begin
      if (strb.relGo) relPkt <= relSel;
      allocDone <= strb.allocGo;
      if (strb.allocGo)
        allocResult <= fitFound ? {2'b00, PKT_W'(fitStart)} : {1'b1, {(PKT_W+1){1'b0}}};
    end
  end

  pgalloc_fifo #(.W(PKT_W), .DEPTH(QDEPTH)) u_rxQ (
    .clk(clk), .rstN(rstN), .clr(strb.clrAll), .push(strb.rxPush), .pop(strb.rxPop),
    .din(rxPushPkt), .head(rxHead), .empty(rxEmpty));

  pgalloc_fifo #(.W(PKT_W), .DEPTH(QDEPTH)) u_txQ (
    .clk(clk), .rstN(rstN), .clr(strb.clrAll || strb.clrTx), .push(strb.txPush),
    .pop(strb.txPop), .din(hostPkt), .head(txHead), .empty(txEmpty));

  pgalloc_fifo #(.W(PKT_W), .DEPTH(QDEPTH)) u_doneQ (
    .clk(clk), .rstN(rstN), .clr(strb.clrAll || strb.clrTx), .push(strb.donePush),
    .pop(strb.donePop), .din(txHead), .head(doneHead), .empty(doneEmpty));

  AST_ALLOC_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strb.allocGo |=> allocDone)
    else $error("allocate without done pulse"); // R4

  AST_FAIL_NO_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.allocGo && !fitFound && !strb.freeNow && !strb.clrAll) |=> $stable(usedMap))
    else $error("failed allocation changed the page map"); // R3

endmodule

// File: rtl/pgalloc_top.sv
module pgalloc_top
  import pgalloc_pkg::*;
#(
  parameter int NP      = 32,
  parameter int PKT_W   = 6,
  parameter int REQ_W   = 5,
  parameter int QDEPTH  = 32,
  parameter int REL_CYC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [REQ_W+2:0]   cmdWord,
  input  logic [PKT_W-1:0]   pktNumIn,
  input  logic               autoRelease,
  input  logic               rxPushValid,
  input  logic [PKT_W-1:0]   rxPushPkt,
  input  logic               txPopValid,
  input  logic               txPopOk,
  input  logic               doneRead,
  output logic [PKT_W+1:0]   allocResult,
  output logic               allocDone,
  output logic               busy,
  output logic [15:0]        rxFifoPort,
  output logic [PKT_W+1:0]   txFifoPort,
  output logic               txHeadValid,
  output logic [PKT_W-1:0]   txHeadPkt
);
  localparam int RX_PAD = 16 - 1 - PKT_W;

  strobes_t         strb;
  logic             rxEmpty, txEmpty, doneEmpty;
  logic [PKT_W-1:0] rxHead, txHead, doneHead;

  pgalloc_ctrl #(.REL_CYC(REL_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdWord[REQ_W+2:REQ_W]),
    .autoRelease(autoRelease), .rxPushValid(rxPushValid), .txPopValid(txPopValid),
    .txPopOk(txPopOk), .doneRead(doneRead), .rxEmpty(rxEmpty), .txEmpty(txEmpty),
    .strb(strb), .busy(busy));

  pgalloc_dp #(.NP(NP), .PKT_W(PKT_W), .REQ_W(REQ_W), .QDEPTH(QDEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .allocCode(cmdWord[REQ_W-1:0]),
    .hostPkt(pktNumIn), .rxPushPkt(rxPushPkt), .allocResult(allocResult),
    .allocDone(allocDone), .rxEmpty(rxEmpty), .txEmpty(txEmpty), .doneEmpty(doneEmpty),
    .rxHead(rxHead), .txHead(txHead), .doneHead(doneHead));

  assign rxFifoPort  = {rxEmpty, {RX_PAD{1'b0}}, rxEmpty ? {PKT_W{1'b0}} : rxHead};
  assign txFifoPort  = {doneEmpty, 1'b0, doneEmpty ? {PKT_W{1'b0}} : doneHead};
  assign txHeadValid = !txEmpty;
  assign txHeadPkt   = txEmpty ? {PKT_W{1'b0}} : txHead;

endmodule

// File: tb/pgalloc_top_bench.sv
module pgalloc_top_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [7:0] cmdWord = '0;
  logic [5:0] pktNumIn = '0;
  logic       autoRelease = 1'b0;
  logic       rxPushValid = 1'b0;
  logic [5:0] rxPushPkt = '0;
  logic       txPopValid = 1'b0;
  logic       txPopOk = 1'b0;
  logic       doneRead = 1'b0;
  logic [7:0] allocResult;
  logic       allocDone, busy, txHeadValid;
  logic [15:0] rxFifoPort;
  logic [7:0] txFifoPort;
  logic [5:0] txHeadPkt;

  int nChk = 0;
  int nBad = 0;
  int cyc = 0;

  always #10 clk = ~clk; // 50 MHz

  pgalloc_top u_pgalloc_top (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord), .pktNumIn(pktNumIn),
    .autoRelease(autoRelease), .rxPushValid(rxPushValid), .rxPushPkt(rxPushPkt),
    .txPopValid(txPopValid), .txPopOk(txPopOk), .doneRead(doneRead),
    .allocResult(allocResult), .allocDone(allocDone), .busy(busy), .rxFifoPort(rxFifoPort),
    .txFifoPort(txFifoPort), .txHeadValid(txHeadValid), .txHeadPkt(txHeadPkt));

  // reference model state
  bit mUsed [32];
  int mLen [32];
  int mRx[$];
  int mTx[$];
  int mDone[$];
  int mRelCnt, mRelPkt, mResult;
  bit mDoneP;

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int findFit(int need);
    for (int s = 0; s + need <= 32; s++) begin
      bit ok = 1;
      for (int k = 0; k < need; k++) if (mUsed[s + k]) ok = 0;
      if (ok) return s;
    end
    return -1;
  endfunction

  task automatic modelReset();
    foreach (mUsed[i]) begin mUsed[i] = 0; mLen[i] = 0; end
    mRx.delete(); mTx.delete(); mDone.delete();
    mRelCnt = 0; mRelPkt = 0; mResult = 8'h80; mDoneP = 0;
  endtask

  task automatic modelStep(bit cv, int cw, int pk, bit ar, bit rpv, int rpp, bit tpv, bit tok, bit dr);
    int op = cv ? (cw >> 5) & 7 : 0;
    bit busyOld = (mRelCnt != 0);
    bit clrAll = (op == 2);
    bit clrTx = (op == 7);
    bit hostFree = (op == 5) && !busyOld;
    bit rxRel = (op == 4) && !busyOld && (mRx.size() > 0);
    bit txAcc = tpv && (mTx.size() > 0) && !clrAll && !clrTx;
    bit autoRel = txAcc && tok && ar && !busyOld && !hostFree && !rxRel;
    bit freeNow = (mRelCnt == 1) && !clrAll;
    int need = (cw & 31) + 1;
    int fit = findFit(need);
    int txHeadOld = (mTx.size() > 0) ? mTx[0] : 0;
    int newRel = hostFree ? pk : rxRel ? mRx[0] : autoRel ? txHeadOld : mRelPkt;
    if (freeNow && mRelPkt < 32) begin
      for (int i = mRelPkt; i < mRelPkt + mLen[mRelPkt]; i++) mUsed[i] = 0;
      mLen[mRelPkt] = 0;
    end
    if (op == 1 && fit >= 0) begin
      for (int i = fit; i < fit + need; i++) mUsed[i] = 1;
      mLen[fit] = need;
    end
    mDoneP = (op == 1);
    if (op == 1) mResult = (fit >= 0) ? fit : 8'h80;
    if (clrAll) begin
      foreach (mUsed[i]) begin mUsed[i] = 0; mLen[i] = 0; end
      mRx.delete(); mTx.delete(); mDone.delete();
      mRelCnt = 0;
    end else begin
      if ((op == 3 || rxRel) && mRx.size() > 0) void'(mRx.pop_front());
      if (rpv && mRx.size() < 32) mRx.push_back(rpp);
      if (clrTx) begin
        mTx.delete(); mDone.delete();
      end else begin
        if (txAcc) void'(mTx.pop_front());
        if (op == 6 && mTx.size() < 32) mTx.push_back(pk);
        if (dr && mDone.size() > 0) void'(mDone.pop_front());
        if (txAcc && !autoRel && mDone.size() < 32) mDone.push_back(txHeadOld);
      end
      if (hostFree || rxRel || autoRel) begin
        mRelCnt = 4; mRelPkt = newRel;
      end else if (mRelCnt > 0) mRelCnt--;
    end
  endtask

  task automatic compareAll();
    chk((mResult == 8'h80) ? "R3 allocResult" : "R2 allocResult", allocResult, mResult);
    chk("R4 allocDone", allocDone, mDoneP);
    chk("R5 busy", busy, mRelCnt != 0);
    chk("R7 rxFifoPort", rxFifoPort, (mRx.size() == 0) ? 16'h8000 : mRx[0]);
    chk("R9 txFifoPort", txFifoPort, (mDone.size() == 0) ? 8'h80 : mDone[0]);
    chk("R8 txHeadValid", txHeadValid, mTx.size() > 0);
    chk("R8 txHeadPkt", txHeadPkt, (mTx.size() == 0) ? 0 : mTx[0]);
  endtask

  task automatic cycle(bit cv, int cw, int pk, bit rpv, int rpp, bit tpv, bit tok, bit dr);
    cmdValid = cv; cmdWord = cw[7:0]; pktNumIn = pk[5:0];
    rxPushValid = rpv; rxPushPkt = rpp[5:0];
    txPopValid = tpv; txPopOk = tok; doneRead = dr;
    modelStep(cv, cw, pk, autoRelease, rpv, rpp, tpv, tok, dr);
    @(posedge clk);
    @(negedge clk);
    compareAll();
    cmdValid = 0; rxPushValid = 0; txPopValid = 0; doneRead = 0;
  endtask

  task automatic cmd(int cw, int pk = 0);
    cycle(1, cw, pk, 0, 0, 0, 0, 0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nBad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int busyCycles;
    void'($urandom(32'd4242));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R13 reset state
    chk("R13 allocResult", allocResult, 8'h80);
    chk("R13 busy", busy, 0);
    chk("R13 allocDone", allocDone, 0);
    chk("R13 rxFifoPort", rxFifoPort, 16'h8000);
    chk("R13 txFifoPort", txFifoPort, 8'h80);
    chk("R13 txHeadValid", txHeadValid, 0);

    cmd(8'h22); chk("R2 alloc 3 pages", allocResult, 0);
    cmd(8'h27); chk("R2 alloc 8 pages", allocResult, 3);
    chk("R4 done pulse", allocDone, 1);
    cmd(8'h20); chk("R2 alloc 1 page", allocResult, 11);
    cmd(8'h1F); chk("R1 nop keeps result", allocResult, 11);
    chk("R1 nop no done", allocDone, 0);

    cycle(0, 0, 0, 1, 3, 0, 0, 0);
    cycle(0, 0, 0, 1, 11, 0, 0, 0);
    chk("R7 rx head", rxFifoPort, 16'h0003);
    cmd(8'h60); chk("R6 drop shows next", rxFifoPort, 16'h000B);
    chk("R6 drop not busy", busy, 0);
    cmd(8'h80); chk("R7 rx empty", rxFifoPort, 16'h8000);
    busyCycles = 0;
    while (busy && busyCycles < 10) begin busyCycles++; idle(1); end
    chk("R5 busy length", busyCycles, 4);
    cmd(8'h20); chk("R6 release freed page", allocResult, 11);
    cmd(8'h21); chk("R2 alloc 2 pages", allocResult, 12);

    cmd(8'hA0, 3);
    cmd(8'hA0, 0);  // ignored, busy
    idle(5);
    cmd(8'h27); chk("R5 freed pkt 3 reused", allocResult, 3);
    cmd(8'h22); chk("R5 ignored free kept pages", allocResult, 14);

    cmd(8'h27); chk("R2 alloc 8 at 17", allocResult, 17);
    cmd(8'h27); chk("R3 no room fails", allocResult, 8'h80);
    cmd(8'h26); chk("R3 nothing taken", allocResult, 25);
    cmd(8'h20); chk("R3 full fails", allocResult, 8'h80);

    cmd(8'hC0, 17); cmd(8'hC0, 25);
    chk("R8 tx head", txHeadPkt, 17);
    cycle(0, 0, 0, 0, 0, 1, 1, 0);
    chk("R9 done queue gets pkt", txFifoPort, 8'h11);
    chk("R8 next tx head", txHeadPkt, 25);
    autoRelease = 1;
    cycle(0, 0, 0, 0, 0, 1, 1, 0);
    chk("R9 auto release busy", busy, 1);
    chk("R9 done unchanged", txFifoPort, 8'h11);
    autoRelease = 0;
    idle(5);
    cmd(8'h26); chk("R9 auto release freed", allocResult, 25);
    cycle(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R9 done popped", txFifoPort, 8'h80);

    cmd(8'hC0, 12); cmd(8'hC0, 11);
    cycle(0, 0, 0, 1, 5, 1, 1, 0);
    cmd(8'hE0);
    chk("R11 tx empty", txHeadValid, 0);
    chk("R11 done empty", txFifoPort, 8'h80);
    chk("R11 rx kept", rxFifoPort, 16'h0005);
    cmd(8'h20); chk("R11 pages kept", allocResult, 8'h80);

    cmd(8'h40);
    chk("R10 rx empty", rxFifoPort, 16'h8000);
    chk("R10 result kept", allocResult, 8'h80);
    cmd(8'h3F); chk("R10 all pages free", allocResult, 0);
    cmd(8'h40);

    for (int i = 0; i < 32; i++) cycle(0, 0, 0, 1, i, 0, 0, 0);
    cycle(0, 0, 0, 1, 40, 0, 0, 0);
    for (int i = 0; i < 31; i++) cmd(8'h60);
    chk("R12 last kept entry", rxFifoPort, 16'h001F);
    cmd(8'h60); chk("R12 extra push dropped", rxFifoPort, 16'h8000);
    cmd(8'h40);

    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 100;
      int op = (r < 2) ? 2 : (r < 4) ? 7 : (r < 30) ? 1 : (r < 45) ? 0 : 3 + ($urandom % 4);
      int code = ($urandom % 4 == 0) ? $urandom % 32 : $urandom % 6;
      int pk = ($urandom % 16 == 0) ? 40 : $urandom % 32;
      if ($urandom % 50 == 0) autoRelease = ~autoRelease;
      cycle($urandom % 2, (op << 5) | code, pk, ($urandom % 4) == 0, $urandom % 32,
            ($urandom % 3) == 0, $urandom % 2, ($urandom % 4) == 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule